// File: doc/BRIEF.md
# Frame-Paced Pixel Grabber

This block lets a controller dump a full surface image through a single byte-wide register, at a rate of one pixel per frame. A pixel stream arrives on its own port: a frame-start marker, a beat-valid strobe, a linear pixel index and a 6-bit pixel value. The grabber holds a pixel pointer. Each register access arms a capture. A capture takes the pointed pixel from the first frame that begins after the arming. Reading the register returns the captured value with two flags. Each successful read moves the pointer to the next pixel.

With the default 18 x 18 array, a complete dump takes 324 frames. A write to the register starts the dump over at the first pixel. The controller then polls with reads. A read that finds no data returns zero and leaves the pointer where it is. A read that finds data consumes that data and requests the next pixel.

Top module: `pixel_grab`

## Requirements
- R1: After reset the register reads 0x00, the pointer is at the first pixel (index 0) and nothing is armed. Frames that stream past without any access never set data-valid.
- R2: The read byte is {start-of-frame, data-valid, value[5:0]}, with start-of-frame in bit 7, data-valid in bit 6 and the value in bits 5..0. Start-of-frame is 1 exactly when the held pixel is index 0. While data-valid is 0, the whole byte is 0x00.
- R3: Any write resets the pointer to index 0, clears data-valid and arms a capture. The next pixel returned carries start-of-frame = 1.
- R4: An armed capture only considers beats from a frame whose frame-start beat comes after the arming access. A matching index seen before that frame-start is ignored.
- R5: At most one pixel is captured per arming. Once data-valid is set, later frames leave the byte unchanged until the next access.
- R6: A read that returns data-valid = 1 advances the pointer by one, clears data-valid and re-arms.
- R7: A read that returns data-valid = 0 returns 0x00 and does not move the pointer. It arms the grabber if the grabber is idle, and otherwise leaves a capture that is already pending undisturbed.
- R8: After the valid read of the last pixel (index 323), the pointer wraps to index 0, and the next returned pixel has start-of-frame = 1.
- R9: Pointer k selects stream index k, where index = column x 18 + row, row 0 is the bottom of a column and column 0 is the first column. Pixel 1 is the bottom of the first column; pixel 324 is the top of the last column.
- R10: When a read and a write strobe in the same cycle, the write takes effect and the read does not advance the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe; the data byte is ignored |
| reg_rd | input | 1 | Register read strobe; rd_data is consumed in this cycle |
| pix_sof | input | 1 | Marks the first beat of a frame |
| pix_valid | input | 1 | Pixel beat valid |
| pix_idx | input | 9 | Linear index of the beat (column x ROWS + row) |
| pix_data | input | 6 | Pixel value |
| rd_data | output | 8 | {start-of-frame, data-valid, value} |

## Verification
The bench places a beat with the pointed index ahead of any frame-start. A grabber that ignores the frame boundary would latch that beat and return the wrong value. Each frame carries its own value offset. A capture from the wrong frame, or one that is later overwritten, therefore shows up as a value mismatch. The bench walks all 324 pixels in column order and then one pixel more, so a bad wrap or a wrong start-of-frame flag is caught at pixel 1 and at pixel 325. It also issues reads that find no data, and a read and a write in the same cycle. A pointer that moves on an empty read, or on a read that collides with a write, would return the wrong pixel on the next valid read.

// File: rtl/pixel_grab.sv
module pixel_grab #(
  parameter int ROWS = 18,
  parameter int COLS = 18,
  parameter int PW = 6,
  localparam int NPIX = ROWS * COLS,
  localparam int IW = $clog2(NPIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          pix_sof,
  input  logic          pix_valid,
  input  logic [IW-1:0] pix_idx,
  input  logic [PW-1:0] pix_data,
  output logic [PW+1:0] rd_data
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HUNT} grab_st_e;

  grab_st_e      st;
  logic [IW-1:0] ptr;
  logic          vld;
  logic [PW-1:0] val;

  wire hunting = (st == ST_HUNT) || (st == ST_WAIT && pix_sof);
  wire hit     = hunting && pix_valid && (pix_idx == ptr);
  wire take    = reg_rd && !reg_wr && vld;
  wire [IW-1:0] ptr_nxt = (ptr == IW'(NPIX - 1)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      ptr <= '0;
      vld <= 1'b0;
      val <= '0;
    end else if (reg_wr) begin
      st  <= ST_WAIT;
      ptr <= '0;
      vld <= 1'b0;
    end else if (take) begin
      st  <= ST_WAIT;
      ptr <= ptr_nxt;
      vld <= 1'b0;
    end else if (hit) begin
      st  <= ST_IDLE;
      vld <= 1'b1;
      val <= pix_data;
    end else if (st == ST_WAIT && pix_sof) begin
      st <= ST_HUNT;
    end else if (st == ST_IDLE && reg_rd) begin
      st <= ST_WAIT;
    end
  end

  assign rd_data = vld ? {ptr == '0, 1'b1, val} : '0;

endmodule

// File: rtl/pixel_grab_chk.sv
module pixel_grab_chk #(
  parameter int PW = 6,
  parameter int IW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          pix_valid,
  input logic [IW-1:0] pix_idx,
  input logic [PW+1:0] rd_data
);

  // R3
  wr_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !rd_data[PW]);

  // R6
  read_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && rd_data[PW]) |=> !rd_data[PW]);

  // R2
  empty_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[PW] |-> (rd_data == '0));

  // R5
  held_until_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[PW] && !reg_rd && !reg_wr) |=> $stable(rd_data));

  // R4
  capture_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[PW]) |-> $past(pix_valid));

endmodule

bind pixel_grab pixel_grab_chk #(.PW(PW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .pix_valid(pix_valid), .pix_idx(pix_idx), .rd_data(rd_data)
);

// File: tb/test_pixel_grab.sv
module test_pixel_grab;
  localparam int ROWS = 18, COLS = 18, NPIX = ROWS * COLS;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic pix_sof = 0, pix_valid = 0;
  logic [8:0] pix_idx = '0;
  logic [5:0] pix_data = '0;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  int fr = 0;

  pixel_grab i_pixel_grab (.*);

  always #4 clk = ~clk;

  function automatic logic [5:0] pv(int col, int row, int f);
    return 6'((col * ROWS + row) * 5 + f * 11 + 1);
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic frame();
    fr++;
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) begin
        @(negedge clk);
        pix_sof = (c == 0 && r == 0);
        pix_valid = 1;
        pix_idx = 9'(c * ROWS + r);
        pix_data = pv(c, r, fr);
      end
    @(negedge clk);
    pix_sof = 0; pix_valid = 0;
  endtask

  task automatic do_read(output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; d = rd_data;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic do_write();
    @(negedge clk); reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  function automatic logic [7:0] exp_byte(int k, int f);
    return {k == 0, 1'b1, pv(k / ROWS, k % ROWS, f)};
  endfunction

  task automatic t_reset();
    @(negedge clk); check("R1 reset", rd_data, 8'h00);
    frame();
    @(negedge clk); check("R1 no arm", rd_data, 8'h00);
  endtask

  task automatic t_first();
    logic [7:0] d;
    do_write();
    check("R3 cleared", rd_data, 8'h00);
    frame();
    @(negedge clk); check("R2 R3 first pixel", rd_data, exp_byte(0, fr));
    frame();
    @(negedge clk); check("R5 held", rd_data, exp_byte(0, fr - 1));
    do_read(d); check("R6 returned", d, exp_byte(0, fr - 1));
    check("R6 consumed", rd_data, 8'h00);
    do_read(d); check("R7 empty read", d, 8'h00);
    frame();
    @(negedge clk); check("R6 R9 next pixel", rd_data, exp_byte(1, fr));
  endtask

  task automatic t_no_advance();
    logic [7:0] d;
    do_read(d); check("R6 second", d, exp_byte(1, fr));
    do_read(d); check("R7 empty a", d, 8'h00);
    do_read(d); check("R7 empty b", d, 8'h00);
    frame();
    do_read(d); check("R7 no advance", d, exp_byte(2, fr));
  endtask

  task automatic t_prior_frame();
    do_write();
    @(negedge clk);
    pix_valid = 1; pix_sof = 0; pix_idx = 0; pix_data = 6'h2a;
    @(negedge clk); pix_valid = 0;
    @(negedge clk); check("R4 no frame start", rd_data, 8'h00);
    frame();
    @(negedge clk); check("R4 next frame", rd_data, exp_byte(0, fr));
  endtask

  task automatic t_collide();
    logic [7:0] d;
    do_read(d); check("R6 before collide", d, exp_byte(0, fr));
    frame();
    @(negedge clk); check("R9 pixel 1", rd_data, exp_byte(1, fr));
    reg_rd = 1; reg_wr = 1;
    @(negedge clk); reg_rd = 0; reg_wr = 0;
    check("R10 cleared", rd_data, 8'h00);
    frame();
    @(negedge clk); check("R10 write wins", rd_data, exp_byte(0, fr));
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    do_write();
    for (int k = 0; k < NPIX; k++) begin
      frame();
      do_read(d); check("R8 R9 walk", d, exp_byte(k, fr));
    end
    frame();
    do_read(d); check("R8 wrap", d, exp_byte(0, fr));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_first();
    t_no_advance();
    t_prior_frame();
    t_collide();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule